// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block holds a bank of 32 message mailboxes on the transmit side of a CAN controller and decides which pending mailbox is handed to the frame sender next. Software fills a mailbox's identifier word and control word through a flat register port. It marks the mailbox as a transmit mailbox and enables it, then posts a request by writing ones into the request-set register.

Among all mailboxes that are enabled, set to transmit and requested, the arbiter picks the one whose 6-bit priority field is largest. On a tie, the higher-numbered mailbox wins. The chosen mailbox is locked and its decoded frame fields are presented to the sender until the sender reports completion. Completion raises that mailbox's acknowledge bit and withdraws its request. The acknowledge bits, filtered by a mask register, form one interrupt line and a status word that names the lowest-numbered pending source.

Register map (word addresses on `regAddr`): 0x00 enable, 0x01 direction (1 = receive, 0 = transmit), 0x02 request (write-one-to-set, reads the request vector), 0x03 acknowledge (write-one-to-clear), 0x04 interrupt mask, 0x05 status (read only). Mailbox n has its identifier word at 0x40+n and its control word at 0x80+n.

Top module: `can_tx_mbox_arb`

## Requirements
- R1: After reset, the enable, direction, request, acknowledge and mask registers read zero, and `txValid` and `irq` are low.
- R2: A mailbox is a candidate only when its enable bit is 1, its direction bit is 0 and its request bit is 1. A requested mailbox marked receive (direction 1) is never offered.
- R3: Among candidates, the one with the largest priority in control-word bits [13:8] is offered first.
- R4: Among candidates of equal priority, the highest-numbered mailbox is offered first.
- R5: Writing 1 to a bit of the request register (0x02) sets that mailbox's request. Writing 0 leaves it unchanged.
- R6: When `txDone` is high while `txValid` is high, the offered mailbox's acknowledge bit becomes 1 and its request bit is cleared. Writing 1 to an acknowledge bit clears it. Writing 0 leaves it unchanged.
- R7: While `txValid` is high and `txDone` is low, `txMbox` and the frame fields hold steady. A higher-priority request arriving in that window does not pre-empt the offered mailbox.
- R8: The frame fields decode as follows. `txDlc` comes from control bits [3:0]. `txRemote` comes from control bit 4. `txExt` comes from identifier bit 31. `txIdent` is identifier bits [28:0] when `txExt` is 1, and otherwise identifier bits [28:18] placed in the low 11 bits with the rest zero.
- R9: `irq` is high exactly when some acknowledge bit is set whose mask bit is 1. The status word (0x05) carries `irq` in bit 8 and the lowest-numbered such mailbox in bits [4:0].
- R10: `txValid` rises on the clock edge after the one at which a candidate first exists. After an accepted `txDone`, `txValid` is low for at least one cycle before the next offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from `regAddr`) |
| txValid | output | 1 | A mailbox is offered to the frame sender |
| txMbox | output | 5 | Number of the offered mailbox |
| txExt | output | 1 | Offered frame uses extended identifier |
| txIdent | output | 29 | Offered frame identifier, right aligned |
| txDlc | output | 4 | Offered data length code |
| txRemote | output | 1 | Offered frame is a remote request |
| txDone | input | 1 | Sender reports successful transmission |
| irq | output | 1 | Masked acknowledge interrupt |

## Verification
The assertions check four behaviours on every cycle. An offered mailbox stays fixed until completion. A completion always sets that mailbox's acknowledge bit and drops the offer for a cycle. A fresh offer only names a mailbox that was a candidate. The interrupt never rises without an acknowledge bit. Only the bench's scenarios can show the ordering rules: which mailbox wins under mixed priorities, equal priorities and extreme values (0 and 63). The same holds for the identifier and length decoding, for write-zero having no effect, and for the lowest-source report in the status word.

// File: rtl/cantx_pkg.sv
package cantx_pkg;
  localparam int MBOX_CNT = 32;
  localparam int IDX_W    = $clog2(MBOX_CNT);
  localparam int PRIO_W   = 6;
  localparam int PRIO_LSB = 8;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;

  localparam logic [ADDR_W-1:0] ADR_ENABLE = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_DIR    = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_REQ    = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_ACK    = 8'h03;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 8'h05;

  typedef struct packed {
    logic             finish;
    logic [IDX_W-1:0] curIdx;
  } arbStrobe_t;
endpackage

// File: rtl/cantx_mbox_bank.sv
module cantx_mbox_bank
  import cantx_pkg::*;
#(
  parameter int NUM = MBOX_CNT,
  parameter int PW  = PRIO_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  arbStrobe_t         strobe,
  output logic [NUM-1:0]     candVec,
  output logic [NUM*PW-1:0]  prioFlat,
  output logic               txExt,
  output logic [28:0]        txIdent,
  output logic [3:0]         txDlc,
  output logic               txRemote,
  output logic [NUM-1:0]     ackVec,
  output logic [NUM-1:0]     reqVec,
  output logic               irq
);
  localparam int IW = $clog2(NUM);

  logic [NUM-1:0]    enVec, dirVec, maskVec;
  logic [DATA_W-1:0] idMem   [NUM];
  logic [DATA_W-1:0] ctrlMem [NUM];
  logic [NUM-1:0]    doneMask, setMask, clrMask;
  logic              idSel, ctrlSel;
  logic [IW-1:0]     selIdx;
  logic [IW-1:0]     irqSrc;
  logic [NUM-1:0]    pendVec;

  assign selIdx   = regAddr[IW-1:0];
  assign idSel    = (regAddr[7:6] == 2'b01) && (int'(regAddr[5:0]) < NUM);
  assign ctrlSel  = (regAddr[7:6] == 2'b10) && (int'(regAddr[5:0]) < NUM);
  assign doneMask = strobe.finish ? (NUM'(1) << strobe.curIdx) : '0;
  assign setMask  = (regWrEn && regAddr == ADR_REQ) ? regWrData[NUM-1:0] : '0;
  assign clrMask  = (regWrEn && regAddr == ADR_ACK) ? regWrData[NUM-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enVec   <= '0;
      dirVec  <= '0;
      maskVec <= '0;
      reqVec  <= '0;
      ackVec  <= '0;
    end else begin
      if (regWrEn && regAddr == ADR_ENABLE) enVec   <= regWrData[NUM-1:0];
      if (regWrEn && regAddr == ADR_DIR)    dirVec  <= regWrData[NUM-1:0];
      if (regWrEn && regAddr == ADR_MASK)   maskVec <= regWrData[NUM-1:0];
      reqVec <= (reqVec & ~doneMask) | setMask;
      ackVec <= (ackVec & ~clrMask) | doneMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM; i++) begin
        idMem[i]   <= '0;
        ctrlMem[i] <= '0;
      end
    end else if (regWrEn) begin
      if (idSel)   idMem[selIdx]   <= regWrData;
      if (ctrlSel) ctrlMem[selIdx] <= regWrData;
    end
  end

  assign candVec = enVec & ~dirVec & reqVec;

  for (genvar g = 0; g < NUM; g++) begin : gPrio
    assign prioFlat[g*PW +: PW] = ctrlMem[g][PRIO_LSB +: PW];
  end

  // frame field decode of the offered mailbox
  logic [DATA_W-1:0] curId, curCtrl;
  assign curId    = idMem[strobe.curIdx];
  assign curCtrl  = ctrlMem[strobe.curIdx];
  assign txExt    = curId[31];
  assign txIdent  = curId[31] ? curId[28:0] : {18'b0, curId[28:18]};
  assign txDlc    = curCtrl[3:0];
  assign txRemote = curCtrl[4];

  // interrupt: masked acknowledge, lowest source reported
  assign pendVec = ackVec & maskVec;
  assign irq     = |pendVec;
  always_comb begin
    irqSrc = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (pendVec[i]) irqSrc = IW'(i);
    end
  end

  always_comb begin
    regRdData = '0;
    if (idSel) begin
      regRdData = idMem[selIdx];
    end else if (ctrlSel) begin
      regRdData = ctrlMem[selIdx];
    end else begin
      case (regAddr)
        ADR_ENABLE: regRdData[NUM-1:0] = enVec;
        ADR_DIR:    regRdData[NUM-1:0] = dirVec;
        ADR_REQ:    regRdData[NUM-1:0] = reqVec;
        ADR_ACK:    regRdData[NUM-1:0] = ackVec;
        ADR_MASK:   regRdData[NUM-1:0] = maskVec;
        ADR_STAT: begin
          regRdData[8]      = irq;
          regRdData[IW-1:0] = irqSrc;
        end
        default:    regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/cantx_arb_ctrl.sv
module cantx_arb_ctrl
  import cantx_pkg::*;
#(
  parameter int NUM = MBOX_CNT,
  parameter int PW  = PRIO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM-1:0]    candVec,
  input  logic [NUM*PW-1:0] prioFlat,
  input  logic              txDone,
  output arbStrobe_t        strobe,
  output logic              txValid
);
  localparam int IW = $clog2(NUM);

  logic          busy;
  logic [IW-1:0] heldIdx;
  logic          found;
  logic [IW-1:0] bestIdx;
  logic [PW-1:0] bestPrio;

  // scan upward; >= lets a later (higher) index win a tie
  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM; i++) begin
      if (candVec[i] && (!found || prioFlat[i*PW +: PW] >= bestPrio)) begin
        found    = 1'b1;
        bestIdx  = IW'(i);
        bestPrio = prioFlat[i*PW +: PW];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      heldIdx <= '0;
    end else if (busy) begin
      if (txDone) busy <= 1'b0;
    end else if (found) begin
      busy    <= 1'b1;
      heldIdx <= bestIdx;
    end
  end

  assign txValid       = busy;
  assign strobe.finish = busy && txDone;
  assign strobe.curIdx = heldIdx;
endmodule

// File: rtl/can_tx_mbox_arb.sv
module can_tx_mbox_arb
  import cantx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              txValid,
  output logic [IDX_W-1:0]  txMbox,
  output logic              txExt,
  output logic [28:0]       txIdent,
  output logic [3:0]        txDlc,
  output logic              txRemote,
  input  logic              txDone,
  output logic              irq
);
  arbStrobe_t                  strobe;
  logic [MBOX_CNT-1:0]         candVec, ackVec, reqVec;
  logic [MBOX_CNT*PRIO_W-1:0]  prioFlat;

  cantx_mbox_bank #(.NUM(MBOX_CNT), .PW(PRIO_W)) uBank (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .candVec(candVec), .prioFlat(prioFlat), .txExt(txExt),
    .txIdent(txIdent), .txDlc(txDlc), .txRemote(txRemote),
    .ackVec(ackVec), .reqVec(reqVec), .irq(irq)
  );

  cantx_arb_ctrl #(.NUM(MBOX_CNT), .PW(PRIO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .candVec(candVec), .prioFlat(prioFlat),
    .txDone(txDone), .strobe(strobe), .txValid(txValid)
  );

  assign txMbox = strobe.curIdx;
endmodule

// File: rtl/cantx_arb_chk.sv
module cantx_arb_chk
  import cantx_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                txValid,
  input logic [IDX_W-1:0]    txMbox,
  input logic                txDone,
  input logic                irq,
  input logic [MBOX_CNT-1:0] candVec,
  input logic [MBOX_CNT-1:0] ackVec
);
  logic [MBOX_CNT-1:0] candQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) candQ <= '0;
    else       candQ <= candVec;
  end

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txDone) |=> (txValid && $stable(txMbox))); // R7

  AST_DONE_ACKS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txDone) |=> ackVec[$past(txMbox)]); // R6

  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txDone) |=> !txValid); // R10

  AST_OFFER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> candQ[txMbox]); // R2

  AST_IRQ_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ackVec == '0) |-> !irq); // R9
endmodule

bind can_tx_mbox_arb cantx_arb_chk uChk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txMbox(txMbox),
  .txDone(txDone), .irq(irq), .candVec(candVec), .ackVec(ackVec)
);

// File: tb/test_can_tx_mbox_arb.sv
`timescale 1ns/100ps
module test_can_tx_mbox_arb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        txValid;
  logic [4:0]  txMbox;
  logic        txExt;
  logic [28:0] txIdent;
  logic [3:0]  txDlc;
  logic        txRemote;
  logic        txDone = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  can_tx_mbox_arb i_can_tx_mbox_arb (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txValid(txValid),
    .txMbox(txMbox), .txExt(txExt), .txIdent(txIdent), .txDlc(txDlc),
    .txRemote(txRemote), .txDone(txDone), .irq(irq)
  );

  typedef struct packed {
    logic [4:0] a; logic [5:0] pa;
    logic [4:0] b; logic [5:0] pb;
    logic [4:0] c; logic [5:0] pc;
    logic [4:0] e0; logic [4:0] e1; logic [4:0] e2;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  6'd10, 5'd7,  6'd20, 5'd1,  6'd5,  5'd7,  5'd3,  5'd1},
    '{5'd2,  6'd9,  5'd30, 6'd9,  5'd15, 6'd9,  5'd30, 5'd15, 5'd2},
    '{5'd31, 6'd0,  5'd0,  6'd63, 5'd16, 6'd63, 5'd16, 5'd0,  5'd31},
    '{5'd4,  6'd1,  5'd9,  6'd1,  5'd8,  6'd2,  5'd8,  5'd9,  5'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitValid();
    for (int i = 0; i < 20 && !txValid; i++) @(negedge clk);
  endtask

  task automatic pulseDone();
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] m;
    logic [4:0]  exp [3];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 enable", v, 0);
    rd(8'h01, v); chk("R1 dir", v, 0);
    rd(8'h02, v); chk("R1 req", v, 0);
    rd(8'h03, v); chk("R1 ack", v, 0);
    rd(8'h04, v); chk("R1 mask", v, 0);
    chk("R1 txValid", 32'(txValid), 0);
    chk("R1 irq", 32'(irq), 0);

    // table walk: R3 ordering and R4 ties
    for (int n = 0; n < NV; n++) begin
      vec_t t;
      t = VECS[n];
      exp[0] = t.e0; exp[1] = t.e1; exp[2] = t.e2;
      wr(8'h80 + 8'(t.a), 32'({t.pa, 8'h02}));
      wr(8'h80 + 8'(t.b), 32'({t.pb, 8'h02}));
      wr(8'h80 + 8'(t.c), 32'({t.pc, 8'h02}));
      m = (32'd1 << t.a) | (32'd1 << t.b) | (32'd1 << t.c);
      wr(8'h01, 0);
      wr(8'h00, m);
      wr(8'h02, m);
      for (int k = 0; k < 3; k++) begin
        waitValid();
        chk((n == 1) ? "R4 tie order" : "R3 prio order", 32'(txMbox), 32'(exp[k]));
        pulseDone();
      end
      rd(8'h03, v); chk("R6 ack after table", v, m);
      wr(8'h03, 32'hFFFF_FFFF);
      wr(8'h00, 0);
    end

    // R8 fields of mailbox 3 (std id 0x5A3, remote, dlc 6, prio 0)
    wr(8'h43, 32'h5A3 << 18);
    wr(8'h83, 32'h16);
    wr(8'h01, 32'h8);
    wr(8'h00, 32'h8);
    // R5 write-one-to-set
    wr(8'h02, 0); rd(8'h02, v); chk("R5 zero write", v, 0);
    wr(8'h02, 32'h8); rd(8'h02, v); chk("R5 set", v, 32'h8);
    wr(8'h02, 0); rd(8'h02, v); chk("R5 zero keeps", v, 32'h8);
    repeat (3) @(negedge clk);
    chk("R2 receive dir not offered", 32'(txValid), 0);
    wr(8'h01, 0);
    chk("R10 not yet valid", 32'(txValid), 0);
    @(negedge clk);
    chk("R10 valid one edge later", 32'(txValid), 1);
    chk("R2 offered mbox", 32'(txMbox), 3);
    chk("R8 std ident", 32'(txIdent), 32'h5A3);
    chk("R8 ext flag", 32'(txExt), 0);
    chk("R8 dlc", 32'(txDlc), 6);
    chk("R8 remote", 32'(txRemote), 1);

    // R7 lock against late higher-priority request
    wr(8'h4A, 32'h8000_0000 | 32'h1ABC_DEF0);
    wr(8'h8A, 32'h3F08);
    wr(8'h00, 32'h408);
    wr(8'h02, 32'h400);
    repeat (3) @(negedge clk);
    chk("R7 still locked", 32'(txMbox), 3);
    chk("R7 still valid", 32'(txValid), 1);
    pulseDone();
    chk("R10 gap after done", 32'(txValid), 0);
    rd(8'h03, v); chk("R6 ack set", v, 32'h8);
    rd(8'h02, v); chk("R6 req cleared", v, 32'h400);
    @(negedge clk);
    chk("R3 next winner", 32'(txMbox), 10);
    chk("R3 valid", 32'(txValid), 1);
    chk("R8 ext flag", 32'(txExt), 1);
    chk("R8 ext ident", 32'(txIdent), 32'h1ABC_DEF0);
    chk("R8 dlc", 32'(txDlc), 8);
    chk("R8 remote", 32'(txRemote), 0);
    pulseDone();

    // R9 interrupt and status
    chk("R9 masked off", 32'(irq), 0);
    wr(8'h04, 32'h400);
    chk("R9 irq on", 32'(irq), 1);
    rd(8'h05, v); chk("R9 status src 10", v, 32'h10A);
    wr(8'h04, 32'h408);
    rd(8'h05, v); chk("R9 lowest src", v, 32'h103);
    wr(8'h03, 0);
    rd(8'h03, v); chk("R6 zero write keeps ack", v, 32'h408);
    wr(8'h03, 32'h8);
    rd(8'h05, v); chk("R9 after clear 3", v, 32'h10A);
    wr(8'h03, 32'h400);
    chk("R9 irq off", 32'(irq), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule